// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This unit is an execution stage for a 32-bit processor that handles two bit-field operations whose geometry comes from immediates in the instruction word. The first operation is extract. It takes a field from a source operand and returns it right-aligned, with every bit above the field cleared. The second operation is insert. It takes the low-order bits of a source operand and writes them into a copy of the current destination value at a chosen offset. Destination bits outside that field are left as they were.

The pipeline issues one operation per cycle with `in_valid` high. On that cycle it presents the instruction word, the source operand, and the current destination contents; extract ignores the destination contents. The unit samples these on the clock edge. One cycle later it presents the result, together with the destination register index, under `out_valid`.

The two immediates are read differently by the two operations. Extract reads the upper immediate as the field width. Insert reads it as the bit index of the field's most significant bit.

Top module: `bitfield_unit`

## Requirements
- R1: With `op_insert` = 0 and width field `w` = `instr[10:6]` and offset `o` = `instr[4:0]`, result bit i equals `src_a[i+o]` for i < w and i+o < 32, and is 0 for all other bits.
- R2: An extract whose width field is 0 returns a result of all zeros.
- R3: With `op_insert` = 1, top-bit field `m` = `instr[10:6]` and offset `o` = `instr[4:0]`, and m >= o, result bits o through m equal `src_a` bits 0 through m-o.
- R4: For an insert with m >= o, every result bit below o or above m equals the same bit of `dst_old`.
- R5: For an insert whose top-bit field is smaller than its offset, the result equals `dst_old` unchanged.
- R6: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was sampled high, and is low otherwise.
- R7: While `in_valid` is low, `result` and `out_rd` keep the values they last held.
- R8: During and right after reset, `out_valid` is 0, `result` is 0 and `out_rd` is 0.
- R9: `out_rd` presents `instr[25:21]` of the accepted instruction in the same cycle as its result.
- R10: Instruction bits 31:26, 20:11 and 5 have no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| op_insert | input | 1 | 0 selects extract, 1 selects insert |
| instr | input | 32 | Instruction word: offset in [4:0], width/top-bit in [10:6], destination index in [25:21] |
| src_a | input | 32 | Source operand holding the field or the bits to insert |
| dst_old | input | 32 | Current destination contents, used by insert |
| out_valid | output | 1 | Result valid strobe |
| out_rd | output | 5 | Destination register index for the result |
| result | output | 32 | Operation result |

## Verification
The assertions assume that the reset is held for at least one edge, and that `instr`, `src_a` and `dst_old` are stable across the sampling edge while `in_valid` is high. The `$past` comparisons depend on that stability. The assertions place no legality limit on the immediates. An extract whose width and offset add up to more than 32 is still defined, because bits fetched from beyond bit 31 read as zero. An insert whose top bit lies below its offset is defined as a no-op. The stimulus drives every input only at the falling edge. It randomizes the ignored instruction bits on every operation. It mixes legal random geometries with directed corners: offset 0, offset 31, width plus offset exactly 32, a full 32-bit insert, and an inverted insert range.

// File: rtl/bitfield_unit.sv
module bitfield_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        op_insert,
  input  logic [31:0] instr,
  input  logic [31:0] src_a,
  input  logic [31:0] dst_old,
  output logic        out_valid,
  output logic [4:0]  out_rd,
  output logic [31:0] result
);

  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic [4:0]  off;
  logic [4:0]  fld;
  logic [31:0] ext_mask;
  logic [31:0] ins_mask;
  logic [31:0] ext_val;
  logic [31:0] ins_val;
  logic [31:0] nxt_val;

  wire unused_bits = ^{instr[31:26], instr[20:11], instr[5]};

  assign off = instr[4:0];
  assign fld = instr[10:6];

  assign ext_mask = ~(ONES << fld);
  assign ext_val  = (src_a >> off) & ext_mask;

  assign ins_mask = (ONES >> (5'd31 - fld)) & (ONES << off);
  assign ins_val  = (fld < off) ? dst_old
                  : (dst_old & ~ins_mask) | ((src_a << off) & ins_mask);

  assign nxt_val = op_insert ? ins_val : ext_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rd    <= '0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_rd <= instr[25:21];
        result <= nxt_val;
      end
    end
  end

endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        op_insert,
  input logic [4:0]  off,
  input logic [4:0]  fld,
  input logic [4:0]  rd,
  input logic [31:0] dst_old,
  input logic        out_valid,
  input logic [4:0]  out_rd,
  input logic [31:0] result
);

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(out_rd)));

  assert_zero_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_insert && fld == 5'd0) |=> result == 32'd0);

  assert_upper_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_insert) |=> (result >> $past(fld)) == 32'd0);

  assert_inverted_noop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_insert && fld < off) |=> result == $past(dst_old));

  assert_rd_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_rd == $past(rd));

endmodule

bind bitfield_unit bitfield_unit_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_insert (op_insert),
  .off       (instr[4:0]),
  .fld       (instr[10:6]),
  .rd        (instr[25:21]),
  .dst_old   (dst_old),
  .out_valid (out_valid),
  .out_rd    (out_rd),
  .result    (result)
);

// File: tb/bitfield_unit_tb_top.sv
module bitfield_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        op_insert = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] src_a = '0;
  logic [31:0] dst_old = '0;
  logic        out_valid;
  logic [4:0]  out_rd;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic        m_valid = 1'b0;
  logic [4:0]  m_rd = '0;
  logic [31:0] m_res = '0;
  string       m_tag = "R8";

  always #4 clk = ~clk;

  bitfield_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_insert(op_insert),
    .instr(instr), .src_a(src_a), .dst_old(dst_old),
    .out_valid(out_valid), .out_rd(out_rd), .result(result)
  );

  function automatic logic [31:0] ref_extract(logic [31:0] s, int w, int o);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++)
      if (i < w && i + o < 32) r[i] = s[i + o];
    return r;
  endfunction

  function automatic logic [31:0] ref_insert(logic [31:0] s, logic [31:0] d, int m, int o);
    logic [31:0] r = d;
    if (m >= o)
      for (int i = 0; i < 32; i++)
        if (i >= o && i <= m) r[i] = s[i - o];
    return r;
  endfunction

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_outputs();
    check32("R6", {31'd0, out_valid}, {31'd0, m_valid});
    check32(m_tag, result, m_res);
    check32(m_valid ? "R9" : "R7", {27'd0, out_rd}, {27'd0, m_rd});
  endtask

  task automatic step(logic v, logic ins, logic [31:0] iw, logic [31:0] s, logic [31:0] d);
    @(negedge clk);
    compare_outputs();
    in_valid = v; op_insert = ins; instr = iw; src_a = s; dst_old = d;
    m_valid = v;
    if (v) begin
      m_rd = iw[25:21];
      if (!ins) begin
        m_res = ref_extract(s, int'(iw[10:6]), int'(iw[4:0]));
        m_tag = (iw[10:6] == 0) ? "R2 R10" : "R1 R10";
      end else begin
        m_res = ref_insert(s, d, int'(iw[10:6]), int'(iw[4:0]));
        m_tag = (iw[10:6] < iw[4:0]) ? "R5 R10" : "R3 R4 R10";
      end
    end else begin
      m_tag = "R7";
    end
  endtask

  function automatic logic [31:0] mk(int f, int o);
    logic [31:0] r = $urandom;
    r[10:6] = f[4:0];
    r[4:0]  = o[4:0];
    return r;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL R6 watchdog actual %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check32("R8", {31'd0, out_valid}, 32'd0);
    check32("R8", result, 32'd0);
    check32("R8", {27'd0, out_rd}, 32'd0);
    rst_n = 1'b1;

    step(1, 0, mk(8, 0), 32'hDEAD_BEEF, 32'h0);
    step(1, 0, mk(1, 31), 32'h8000_0000, 32'h0);
    step(1, 0, mk(31, 1), 32'hFFFF_FFFF, 32'h0);
    step(1, 0, mk(16, 16), 32'h1234_5678, 32'h0);
    step(1, 0, mk(0, 7), 32'hFFFF_FFFF, 32'h0);
    step(0, 0, $urandom, $urandom, $urandom);
    step(0, 1, $urandom, $urandom, $urandom);
    step(1, 1, mk(31, 0), 32'hA5A5_5A5A, 32'h1111_1111);
    step(1, 1, mk(31, 31), 32'h0000_0001, 32'h0000_0000);
    step(1, 1, mk(7, 4), 32'h0000_00FF, 32'hFFFF_FFFF);
    step(1, 1, mk(3, 9), 32'hFFFF_FFFF, 32'hCAFE_F00D);
    step(1, 1, mk(0, 0), 32'h0, 32'hFFFF_FFFF);
    for (int n = 0; n < 600; n++) begin
      int o = $urandom_range(31);
      int w = $urandom_range(32 - o);
      logic ins = 1'($urandom_range(1));
      int f;
      if (ins) f = (w == 0) ? $urandom_range(31) : o + w - 1;
      else f = (w > 31) ? 31 : w;
      step(1'($urandom_range(3) != 0), ins, mk(f, o), $urandom, $urandom);
    end
    step(0, 0, '0, '0, '0);
    step(0, 0, '0, '0, '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule